// File: doc/BRIEF.md
# ATA Task-File Command Engine

This block is the device side of an ATA register file. A host reaches eight byte-wide registers and one 16-bit data port through a 3-bit address. The engine keeps the addressing registers and the device-select byte. It decodes two commands, IDENTIFY DEVICE and FLUSH CACHE, and sequences the busy, ready, data-request and error status bits for each command. It also drives an interrupt request line. Any other opcode is aborted.

IDENTIFY makes the engine stream a 256-word identification record through the data port. These words are computed on the fly from parameters rather than read from a memory. The host sets the pace: each read strobe on the data address consumes one word. There is no back-pressure in either direction, and a read strobe made while no transfer is pending has no effect. FLUSH CACHE hands the work to the storage side through a level request. The engine holds busy until the storage side returns a one-cycle done or fail pulse.

Top module: `tf_taskfile_engine`

## Requirements
- R1: After reset, status (address 7) reads 0x40, the error register (address 1) reads 0x00, `irq` is low and `flush_req` is low.
- R2: Writes to addresses 2 to 6 are stored and read back on `host_rdata[7:0]` with the upper byte zero. A write to address 1 (feature) never shows up on a read of address 1, which returns the error register.
- R3: After IDENTIFY (0xEC), status reads 0x48 (ready and data-request) before each of the 256 data-port reads, and words come out in index order. After the 256th read, status reads 0x40.
- R4: The identification words are as follows. Word 0 is 0x0040 and word 49 is 0x0200. Words 10 to 19 hold the 20-character serial string and words 23 to 26 hold the 8-character firmware string. In these strings each word carries the earlier character in its high byte. Word 85 has bit 5 set when write caching is enabled. All other words are 0.
- R5: FLUSH CACHE (0xE7) makes status read 0xC0 with `flush_req` high on the next cycle. Both hold until a `flush_done` pulse, after which status reads 0x40 and `flush_req` is low.
- R6: A `flush_fail` pulse during a flush ends it with status 0x41 and error register 0x04 (abort is bit 2).
- R7: An unknown opcode completes on the next cycle with status 0x41 and error register 0x04.
- R8: An accepted command clears any earlier ERR bit and the error register.
- R9: `irq` rises when IDENTIFY data is ready, when a flush ends, or when a command is aborted. A status read clears it. Reads of other addresses leave it set.
- R10: While busy, writes to addresses 1 to 7 are ignored. While a data transfer is pending, command writes are ignored.
- R11: Device register bit 4 selects the drive and reads back as written. A command written while bit 4 differs from `DRIVE_ID` is ignored.
- R12: A data-port read with no transfer pending returns 0 and leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Flush request to the storage side |
| flush_done | input | 1 | One-cycle flush completion pulse |
| flush_fail | input | 1 | One-cycle flush failure pulse |

## Verification
The bench builds the engine with the drive number at 0, write caching enabled, and its own 20-character serial and 8-character firmware strings. With these values every byte of both string fields can be compared against an expected value that the bench computes independently. Keeping the record at the full 256 words brings the last-word boundary and the drop of data-request into reach. Selecting drive 1 against the drive-0 build exercises the ignored-command path.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_ERRFT = 3'd1;
  localparam logic [2:0] A_DEV   = 3'd6;
  localparam logic [2:0] A_CMDST = 3'd7;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] ER_ABORT = 8'h04;

  localparam int DEVSEL_BIT = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_XFER, PH_FLUSH} phase_t;
endpackage

// File: rtl/tf_regfile.sv
module tf_regfile #(
  parameter int LO = 2,
  parameter int HI = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               lock,
  output logic [HI:LO][7:0]  regq
);
  for (genvar i = LO; i <= HI; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regq[i] <= '0;
      else if (wr_en && !lock && (int'(addr) == i))
        regq[i] <= wdata;
    end
  end

  AST_REG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en) |=> $stable(regq)); // R10
endmodule

// File: rtl/tf_ident_rom.sv
module tf_ident_rom #(
  parameter int          WORDS    = 256,
  parameter int          SER_BASE = 10,
  parameter int          SER_WDS  = 10,
  parameter int          FW_BASE  = 23,
  parameter int          FW_WDS   = 4,
  parameter logic [16*SER_WDS-1:0] SERIAL = "TF-ENGINE-0000000001",
  parameter logic [16*FW_WDS-1:0]  FWREV  = "FW0.0.01",
  parameter bit          WCACHE   = 1'b1,
  localparam int         IDX_W    = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  localparam int SER_BITS = 16 * SER_WDS;
  localparam int FW_BITS  = 16 * FW_WDS;

  always_comb begin
    word = 16'h0000;
    if (int'(idx) == 0)  word = 16'h0040;
    if (int'(idx) == 49) word = 16'h0200;
    if (int'(idx) == 85) word = {10'd0, WCACHE, 5'd0};
    for (int k = 0; k < SER_WDS; k++)
      if (int'(idx) == SER_BASE + k) word = SERIAL[SER_BITS-1-16*k -: 16];
    for (int k = 0; k < FW_WDS; k++)
      if (int'(idx) == FW_BASE + k) word = FWREV[FW_BITS-1-16*k -: 16];
  end
endmodule

// File: rtl/tf_cmd_fsm.sv
module tf_cmd_fsm
  import tf_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter bit DRIVE_ID = 1'b0,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_op,
  input  logic             dev_sel,
  input  logic             data_rd,
  input  logic             stat_rd,
  input  logic             med_done,
  input  logic             med_fail,
  output logic             bsy,
  output logic             drq,
  output logic             err,
  output logic [7:0]       err_reg,
  output logic             irq,
  output logic             flush_req,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  phase_t phase;
  logic   cmd_go, irq_set;

  assign bsy       = (phase == PH_FLUSH);
  assign drq       = (phase == PH_XFER);
  assign flush_req = bsy;
  assign cmd_go    = cmd_wr && !bsy && !drq && (dev_sel == DRIVE_ID);

  always_comb begin
    irq_set = 1'b0;
    if (cmd_go && cmd_op != OP_FLUSH) irq_set = 1'b1;
    if (bsy && (med_done || med_fail)) irq_set = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      err     <= 1'b0;
      err_reg <= 8'h00;
      idx     <= '0;
      irq     <= 1'b0;
    end else begin
      if (irq_set)      irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
      if (cmd_go) begin
        err     <= 1'b0;
        err_reg <= 8'h00;
        case (cmd_op)
          OP_IDENT: begin phase <= PH_XFER; idx <= '0; end
          OP_FLUSH: phase <= PH_FLUSH;
          default: begin err <= 1'b1; err_reg <= ER_ABORT; end
        endcase
      end else if (phase == PH_FLUSH) begin
        if (med_fail) begin
          phase   <= PH_IDLE;
          err     <= 1'b1;
          err_reg <= ER_ABORT;
        end else if (med_done) begin
          phase <= PH_IDLE;
        end
      end else if (phase == PH_XFER && data_rd) begin
        if (idx == LAST) phase <= PH_IDLE;
        else             idx   <= idx + 1'b1;
      end
    end
  end

  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !med_done && !med_fail) |=> bsy); // R5
  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_reg == ER_ABORT)); // R6
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !irq); // R9
  AST_DRQ_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> $past(data_rd)); // R3
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && cmd_wr && !med_done && !med_fail) |=> (bsy && !drq)); // R10
endmodule

// File: rtl/tf_taskfile_engine.sv
module tf_taskfile_engine
  import tf_pkg::*;
#(
  parameter int         WORDS    = 256,
  parameter bit         DRIVE_ID = 1'b0,
  parameter bit         WCACHE   = 1'b1,
  parameter logic [159:0] SERIAL = "TF-ENGINE-0000000001",
  parameter logic [63:0]  FWREV  = "FW0.0.01",
  localparam int        IDX_W    = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [15:0] host_rdata,
  output logic        irq,
  output logic        flush_req,
  input  logic        flush_done,
  input  logic        flush_fail
);
  logic [6:2][7:0]  regq;
  logic             bsy, drq, err;
  logic [7:0]       err_reg;
  logic [IDX_W-1:0] idx;
  logic [15:0]      id_word;
  logic [7:0]       status;

  tf_regfile #(.LO(2), .HI(6)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr),
    .wdata(host_wdata), .lock(bsy), .regq(regq)
  );

  tf_cmd_fsm #(.WORDS(WORDS), .DRIVE_ID(DRIVE_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(host_wr && host_addr == A_CMDST), .cmd_op(host_wdata),
    .dev_sel(regq[A_DEV][DEVSEL_BIT]),
    .data_rd(host_rd && host_addr == A_DATA),
    .stat_rd(host_rd && host_addr == A_CMDST),
    .med_done(flush_done), .med_fail(flush_fail),
    .bsy(bsy), .drq(drq), .err(err), .err_reg(err_reg), .irq(irq),
    .flush_req(flush_req), .idx(idx)
  );

  tf_ident_rom #(.WORDS(WORDS), .SERIAL(SERIAL), .FWREV(FWREV),
                 .WCACHE(WCACHE)) u_rom (
    .idx(idx), .word(id_word)
  );

  assign status = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = drq ? id_word : 16'h0000;
      A_ERRFT: host_rdata = {8'h00, err_reg};
      A_CMDST: host_rdata = {8'h00, status};
      default: host_rdata = {8'h00, regq[host_addr]};
    endcase
  end

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA && !drq) |-> (host_rdata == 16'h0000)); // R12
endmodule

// File: tb/sim_tf_taskfile_engine.sv
module sim_tf_taskfile_engine;
  localparam int CLK_P = 10;
  localparam logic [159:0] B_SER = "SIMDRIVE-SN-00042XYZ";
  localparam logic [63:0]  B_FW  = "REV1.0.3";

  logic        clk = 0, rst_n = 0, host_wr = 0, host_rd = 0;
  logic [2:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [15:0] host_rdata;
  logic        irq, flush_req;
  logic        flush_done = 0, flush_fail = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  tf_taskfile_engine #(.DRIVE_ID(1'b0), .WCACHE(1'b1), .SERIAL(B_SER),
                       .FWREV(B_FW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .flush_req(flush_req), .flush_done(flush_done),
    .flush_fail(flush_fail)
  );

  function automatic logic [15:0] exp_word(int w);
    if (w == 0)  return 16'h0040;
    if (w == 49) return 16'h0200;
    if (w == 85) return 16'h0020;
    if (w >= 10 && w < 20) begin
      int j = (w - 10) * 2;
      return {B_SER[8*(19-j) +: 8], B_SER[8*(18-j) +: 8]};
    end
    if (w >= 23 && w < 27) begin
      int j = (w - 23) * 2;
      return {B_FW[8*(7-j) +: 8], B_FW[8*(6-j) +: 8]};
    end
    return 16'h0000;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    host_addr = a; host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse(bit fail);
    if (fail) flush_fail = 1; else flush_done = 1;
    @(negedge clk); flush_fail = 0; flush_done = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd7, v); chk("R1 status", v, 16'h40);
    rd(3'd1, v); chk("R1 error", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flush_req", flush_req, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    for (int a = 2; a <= 5; a++) wr(3'(a), 8'(8'h30 + a * 17));
    wr(3'd6, 8'h40);
    for (int a = 2; a <= 5; a++) begin
      rd(3'(a), v); chk("R2 readback", v, 8'h30 + a * 17);
    end
    rd(3'd6, v); chk("R11 device readback drive0", v, 16'h40);
    wr(3'd1, 8'h5A);
    rd(3'd1, v); chk("R2 feature not visible", v, 0);
  endtask

  task automatic t_identify(bit poke);
    logic [15:0] v;
    wr(3'd7, 8'hEC);
    chk("R9 irq on data ready", irq, 1);
    rd(3'd1, v); chk("R9 irq kept by error read", irq, 1);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, v); chk("R3 status per word", v, 16'h48);
      if (i == 0) chk("R9 irq cleared by status read", irq, 0);
      if (poke && i == 5) begin
        wr(3'd7, 8'hE7);
        chk("R10 cmd ignored during transfer", flush_req, 0);
        rd(3'd7, v); chk("R10 status kept", v, 16'h48);
      end
      rd(3'd0, v); chk("R4 ident word", v, exp_word(i));
    end
    rd(3'd7, v); chk("R3 status after last word", v, 16'h40);
    rd(3'd0, v); chk("R12 idle data read zero", v, 0);
    rd(3'd7, v); chk("R12 status unchanged", v, 16'h40);
  endtask

  task automatic t_flush_ok();
    logic [15:0] v;
    wr(3'd7, 8'hE7);
    rd(3'd7, v); chk("R5 busy status", v, 16'hC0);
    chk("R5 flush_req", flush_req, 1);
    repeat (5) @(negedge clk);
    rd(3'd7, v); chk("R5 busy held", v, 16'hC0);
    wr(3'd2, 8'h77);
    wr(3'd7, 8'hEC);
    pulse(0);
    rd(3'd2, v); chk("R10 reg write ignored while busy", v, 16'h30 + 34);
    chk("R9 irq after flush", irq, 1);
    rd(3'd7, v); chk("R5 done status / R10 no identify", v, 16'h40);
    chk("R5 flush_req low", flush_req, 0);
    chk("R9 irq cleared", irq, 0);
  endtask

  task automatic t_flush_fail_and_abort();
    logic [15:0] v;
    wr(3'd7, 8'hE7);
    pulse(1);
    chk("R9 irq after fail", irq, 1);
    rd(3'd7, v); chk("R6 fail status", v, 16'h41);
    rd(3'd1, v); chk("R6 abort code", v, 16'h04);
    wr(3'd7, 8'hE7);
    rd(3'd7, v); chk("R8 err cleared by new cmd", v, 16'hC0);
    rd(3'd1, v); chk("R8 error reg cleared", v, 0);
    pulse(0);
    wr(3'd7, 8'h20);
    chk("R9 irq on abort", irq, 1);
    rd(3'd7, v); chk("R7 unknown opcode status", v, 16'h41);
    rd(3'd1, v); chk("R7 unknown opcode abort", v, 16'h04);
  endtask

  task automatic t_devsel();
    logic [15:0] v;
    wr(3'd7, 8'hE7); pulse(0); rd(3'd7, v);
    wr(3'd6, 8'h10);
    rd(3'd6, v); chk("R11 drive1 readback", v, 16'h10);
    wr(3'd7, 8'h99);
    rd(3'd7, v); chk("R11 cmd ignored other drive", v, 16'h40);
    chk("R11 no irq", irq, 0);
    wr(3'd7, 8'hE7);
    chk("R11 no flush other drive", flush_req, 0);
    wr(3'd6, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_identify(0);
    t_flush_ok();
    t_flush_fail_and_abort();
    t_identify(1);
    t_devsel();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule